// File: doc/BRIEF.md
# E1 CAS Signaling Multiframe Aligner

On an E1 line, time slot 16 carries channel-associated signaling. This block receives that slot's octet once per basic frame, marked by a one-cycle strobe. From the stream it finds the 16-frame signaling multiframe, which repeats every 2 ms. Frame 0 of the multiframe is marked by a zero upper nibble. The block tracks this boundary on its own, with no reference to any CRC-4 multiframe that may run on the same line.

The block has three outputs. The first is a lock flag. The second is the number of the frame most recently received. The third is the time slot 16 octet to send in outgoing frame 0. In that octet the alarm bit Y reports the receive-side lock state, and the spare bits X take a fixed value set by a parameter.

For each aligned frame from 1 to 15, the block also gives a one-cycle signaling strobe. The strobe carries the two channel numbers whose ABCD nibbles sit in that octet, so a separate signaling store can capture them.

Top module: `cas_mf_align`

## Requirements
- R1: After reset the block is unaligned (`mf_aligned`=0), `sig_stb` is 0 and `tx_f0_ts16` is 8'h0F.
- R2: A frame counts as a frame-0 candidate only when two things hold: its upper nibble (bits 7:4) is 0000, and the previous time slot 16 octet was not all zeros. The first octet after reset never counts as a candidate.
- R3: After a candidate, the block checks the octet 16 frames later. If its upper nibble is 0000, `mf_aligned` rises in the cycle after that strobe. Otherwise the search starts again. Zero nibbles between the two octets are ignored.
- R4: While aligned, `frame_num` gives the number of the frame whose octet was last strobed. The number is 0 at the frame that completes alignment and then counts up modulo 16.
- R5: While aligned, a single frame-0 octet with a nonzero upper nibble is tolerated. A second such octet in the very next multiframe drops `mf_aligned` in the cycle after its strobe.
- R6: While aligned, if all 16 octets of one multiframe (frames 0 through 15) are 8'h00, `mf_aligned` drops in the cycle after the frame-15 strobe.
- R7: `tx_f0_ts16` is laid out as follows. Bits 7:4 are 0000. Bit 2 is the Y bit, equal to the inverse of `mf_aligned`. Bits 3, 1 and 0 are the X bits, set by a parameter that defaults to 1. The octet is therefore 8'h0B when aligned and 8'h0F when not.
- R8: `sig_stb` pulses for one cycle, in the cycle after the strobe, for any frame n from 1 to 15 that arrives while the block is aligned. With it, `sig_chan_hi`=n (upper nibble) and `sig_chan_lo`=n+15 (lower nibble). There is no pulse for frame 0 or while the block is unaligned.
- R9: Between strobes the lock state and `frame_num` do not change, and `sig_stb` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ts16_stb | input | 1 | One-cycle strobe that marks a valid time slot 16 octet |
| ts16_rx | input | 8 | Received time slot 16 octet (bit 7 is the first bit on the line) |
| mf_aligned | output | 1 | Signaling multiframe lock |
| frame_num | output | 4 | Number of the frame last received (valid while aligned) |
| tx_f0_ts16 | output | 8 | Time slot 16 octet to send in outgoing frame 0 |
| sig_stb | output | 1 | One-cycle strobe: the octet just received holds signaling for two channels |
| sig_chan_hi | output | 5 | Channel number of the upper nibble |
| sig_chan_lo | output | 5 | Channel number of the lower nibble |

## Verification
Suppose the frame counter slips after lock. Then `frame_num` is wrong at the very next strobe. In addition, `sig_stb` pulses on the real frame 0, or skips one, within a single multiframe. The loss criteria fail more slowly. A wrong bad-frame count or a wrong all-zero flag shows only at a multiframe boundary, up to 32 frames later. At that point `mf_aligned` and the Y bit of `tx_f0_ts16` flip too early or too late by one multiframe. A wrong candidate rule shows 16 frames after the stray zero nibble, as a lock that should not have happened.

// File: rtl/cas_pkg.sv
package cas_pkg;
  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_CONF  = 2'd1,
    ST_ALIGN = 2'd2
  } cas_state_e;
endpackage

// File: rtl/cas_rst_sync.sv
module cas_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/cas_mf_tracker.sv
module cas_mf_tracker
  import cas_pkg::*;
#(
  parameter int FRAMES   = 16,
  parameter int LOSS_BAD = 2,
  localparam int FW      = $clog2(FRAMES),
  localparam int BW      = $clog2(LOSS_BAD + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb,
  input  logic [7:0]    octet,
  output logic          aligned,
  output logic [FW-1:0] fnum,
  output logic [FW-1:0] fnum_next
);
  localparam logic [FW-1:0] LAST_F = FW'(FRAMES - 1);
  localparam logic [BW-1:0] BAD_LIM = BW'(LOSS_BAD);

  cas_state_e    state_q, state_d;
  logic [FW-1:0] fnum_q, fnum_d;
  logic          pnz_q, pnz_d;
  logic [BW-1:0] bad_q, bad_d;
  logic          allz_q, allz_d;

  logic nib_zero, oct_zero, at_f0;
  logic [BW-1:0] bad_inc;

  assign nib_zero  = (octet[7:4] == 4'b0000);
  assign oct_zero  = (octet == 8'h00);
  assign fnum_next = fnum_q + 1'b1;
  assign at_f0     = (fnum_next == '0);
  assign bad_inc   = bad_q + 1'b1;

  always_comb begin
    state_d = state_q;
    fnum_d  = fnum_q;
    pnz_d   = pnz_q;
    bad_d   = bad_q;
    allz_d  = allz_q;
    if (stb) begin
      pnz_d = !oct_zero;
      unique case (state_q)
        ST_HUNT: begin
          if (nib_zero && pnz_q) begin
            state_d = ST_CONF;
            fnum_d  = '0;
          end
        end
        ST_CONF: begin
          fnum_d = fnum_next;
          if (at_f0) begin
            state_d = nib_zero ? ST_ALIGN : ST_HUNT;
            bad_d   = '0;
            allz_d  = oct_zero;
          end
        end
        ST_ALIGN: begin
          fnum_d = fnum_next;
          if (at_f0) begin
            allz_d = oct_zero;
            if (nib_zero) begin
              bad_d = '0;
            end else if (bad_inc >= BAD_LIM) begin
              bad_d   = '0;
              state_d = ST_HUNT;
            end else begin
              bad_d = bad_inc;
            end
          end else begin
            allz_d = allz_q && oct_zero;
            if (fnum_next == LAST_F && allz_q && oct_zero) begin
              state_d = ST_HUNT;
              bad_d   = '0;
            end
          end
        end
        default: state_d = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      fnum_q  <= '0;
      pnz_q   <= 1'b0;
      bad_q   <= '0;
      allz_q  <= 1'b0;
    end else if (stb) begin
      state_q <= state_d;
      fnum_q  <= fnum_d;
      pnz_q   <= pnz_d;
      bad_q   <= bad_d;
      allz_q  <= allz_d;
    end
  end

  assign aligned = (state_q == ST_ALIGN);
  assign fnum    = fnum_q;

  // R9: nothing moves without a strobe
  a_r9_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> ($stable(fnum_q) && $stable(state_q)));

  // R3: lock is always entered on a frame-0 boundary
  a_r3_lock_at_f0: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aligned) |-> (fnum_q == '0));

  // R4: frame number steps by one per strobe while locked
  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && aligned) |=> (fnum_q == FW'($past(fnum_q) + 1'b1)));

  // R5, R6: lock is lost only at frame 0 or frame 15
  a_r5_loss_point: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(aligned) |-> (fnum_q == '0 || fnum_q == LAST_F));
endmodule

// File: rtl/cas_chan_map.sv
module cas_chan_map #(
  parameter int FRAMES = 16,
  localparam int FW    = $clog2(FRAMES),
  localparam int CW    = $clog2(2 * FRAMES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb,
  input  logic          aligned,
  input  logic [FW-1:0] in_frame,
  output logic          sig_stb,
  output logic [CW-1:0] chan_hi,
  output logic [CW-1:0] chan_lo
);
  logic          stb_d;
  logic [CW-1:0] hi_q, hi_d, lo_q, lo_d;
  logic          stb_q;
  logic          take;

  assign take  = stb && aligned && (in_frame != '0);
  assign stb_d = take;

  always_comb begin
    hi_d = hi_q;
    lo_d = lo_q;
    if (take) begin
      hi_d = CW'(in_frame);
      lo_d = CW'(in_frame) + CW'(FRAMES - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= 1'b0;
      hi_q  <= '0;
      lo_q  <= '0;
    end else begin
      stb_q <= stb_d;
      if (take) begin
        hi_q <= hi_d;
        lo_q <= lo_d;
      end
    end
  end

  assign sig_stb = stb_q;
  assign chan_hi = hi_q;
  assign chan_lo = lo_q;

  // R8: frame 0 never yields a channel strobe
  a_r8_no_frame0: assert property (@(posedge clk) disable iff (!rst_n)
    sig_stb |-> (chan_hi != '0));

  // R8: channel strobe is a single-cycle pulse
  a_r8_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_stb && !$past(stb)) |-> 1'b0);
endmodule

// File: rtl/cas_mf_align.sv
module cas_mf_align #(
  parameter int         FRAMES   = 16,
  parameter int         LOSS_BAD = 2,
  parameter logic [2:0] X_BITS   = 3'b111,
  localparam int        FW       = $clog2(FRAMES),
  localparam int        CW       = $clog2(2 * FRAMES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ts16_stb,
  input  logic [7:0]    ts16_rx,
  output logic          mf_aligned,
  output logic [FW-1:0] frame_num,
  output logic [7:0]    tx_f0_ts16,
  output logic          sig_stb,
  output logic [CW-1:0] sig_chan_hi,
  output logic [CW-1:0] sig_chan_lo
);
  logic          srst_n;
  logic          locked;
  logic [FW-1:0] fnum, fnum_next;

  cas_rst_sync #(.STAGES(2)) u_rsync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  cas_mf_tracker #(.FRAMES(FRAMES), .LOSS_BAD(LOSS_BAD)) u_trk (
    .clk       (clk),
    .rst_n     (srst_n),
    .stb       (ts16_stb),
    .octet     (ts16_rx),
    .aligned   (locked),
    .fnum      (fnum),
    .fnum_next (fnum_next)
  );

  cas_chan_map #(.FRAMES(FRAMES)) u_map (
    .clk      (clk),
    .rst_n    (srst_n),
    .stb      (ts16_stb),
    .aligned  (locked),
    .in_frame (fnum_next),
    .sig_stb  (sig_stb),
    .chan_hi  (sig_chan_hi),
    .chan_lo  (sig_chan_lo)
  );

  // Outgoing frame-0 octet: pattern nibble, X, Y, X, X
  assign tx_f0_ts16 = {4'b0000, X_BITS[2], ~locked, X_BITS[1], X_BITS[0]};
  assign mf_aligned = locked;
  assign frame_num  = fnum;

  // R7: Y bit reports the receive-side lock and the X bits are held
  a_r7_y_bit: assert property (@(posedge clk) disable iff (!srst_n)
    (tx_f0_ts16[2] == !mf_aligned) && (tx_f0_ts16[7:4] == 4'b0000));

  // R8: no channel strobe unless locked one cycle earlier
  a_r8_needs_lock: assert property (@(posedge clk) disable iff (!srst_n)
    sig_stb |-> $past(mf_aligned));
endmodule

// File: tb/cas_mf_align_test.sv
module cas_mf_align_test;
  logic       clk;
  logic       rst_n;
  logic       ts16_stb;
  logic [7:0] ts16_rx;
  logic       mf_aligned;
  logic [3:0] frame_num;
  logic [7:0] tx_f0_ts16;
  logic       sig_stb;
  logic [4:0] sig_chan_hi;
  logic [4:0] sig_chan_lo;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  cas_mf_align uut (
    .clk(clk), .rst_n(rst_n), .ts16_stb(ts16_stb), .ts16_rx(ts16_rx),
    .mf_aligned(mf_aligned), .frame_num(frame_num), .tx_f0_ts16(tx_f0_ts16),
    .sig_stb(sig_stb), .sig_chan_hi(sig_chan_hi), .sig_chan_lo(sig_chan_lo)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // bench reference state
  int         m_st;   // 0 hunt, 1 confirm, 2 locked
  logic [3:0] m_f;
  bit         m_pnz;
  int         m_bad;
  bit         m_z;
  bit         e_sig;
  logic [3:0] e_ch;
  int         gen_f;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_tx(input int st);
    return (st == 2) ? 8'h0B : 8'h0F;
  endfunction

  task automatic mdl_step(input logic [7:0] o);
    bit nz0, z;
    logic [3:0] nf;
    nz0 = (o[7:4] == 4'h0);
    z   = (o == 8'h00);
    nf  = m_f + 4'd1;
    e_sig = (m_st == 2) && (nf != 4'd0);
    e_ch  = nf;
    case (m_st)
      0: if (nz0 && m_pnz) begin m_st = 1; m_f = 4'd0; end
      1: begin
        m_f = nf;
        if (nf == 4'd0) begin m_st = nz0 ? 2 : 0; m_bad = 0; m_z = z; end
      end
      default: begin
        m_f = nf;
        if (nf == 4'd0) begin
          m_z = z;
          if (nz0) m_bad = 0;
          else begin
            m_bad++;
            if (m_bad >= 2) begin m_st = 0; m_bad = 0; end
          end
        end else begin
          if (nf == 4'd15 && m_z && z) begin m_st = 0; m_bad = 0; end
          m_z = m_z && z;
        end
      end
    endcase
    m_pnz = !z;
  endtask

  task automatic compare_all();
    chk(mf_aligned == (m_st == 2), "R3 lock", int'(mf_aligned), int'(m_st == 2));
    chk(tx_f0_ts16 == exp_tx(m_st), "R7 tx octet", int'(tx_f0_ts16), int'(exp_tx(m_st)));
    if (m_st == 2)
      chk(frame_num == m_f, "R4 frame number", int'(frame_num), int'(m_f));
    chk(sig_stb == e_sig, "R8 strobe", int'(sig_stb), int'(e_sig));
    if (e_sig) begin
      chk(sig_chan_hi == {1'b0, e_ch}, "R8 hi channel", int'(sig_chan_hi), int'(e_ch));
      chk(sig_chan_lo == 5'(e_ch + 5'd15), "R8 lo channel", int'(sig_chan_lo), int'(e_ch) + 15);
    end
  endtask

  task automatic send(input logic [7:0] o);
    int gap;
    logic [3:0] f_s;
    logic a_s;
    @(negedge clk);
    ts16_stb = 1'b1;
    ts16_rx  = o;
    @(negedge clk);
    ts16_stb = 1'b0;
    ts16_rx  = $urandom;
    mdl_step(o);
    compare_all();
    f_s = frame_num;
    a_s = mf_aligned;
    gap = 1 + ($urandom % 3);
    repeat (gap) @(negedge clk);
    if (($urandom % 4) == 0) begin
      chk(sig_stb == 1'b0, "R9 idle strobe", int'(sig_stb), 0);
      chk(frame_num == f_s && mf_aligned == a_s, "R9 idle hold",
          int'({a_s, frame_num}), int'({a_s, f_s}));
    end
  endtask

  function automatic logic [7:0] gen_oct(input int k);
    logic [3:0] hi;
    if (k == 0) return 8'h0B;
    hi = 4'(1 + ($urandom % 15));
    return {hi, 4'($urandom)};
  endfunction

  task automatic mf(input int n);
    for (int i = 0; i < n * 16; i++) begin
      send(gen_oct(gen_f));
      gen_f = (gen_f + 1) % 16;
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_st = 0; m_f = 0; m_pnz = 0; m_bad = 0; m_z = 0; e_sig = 0; e_ch = 0;
    gen_f = 0;
    rst_n = 1'b0; ts16_stb = 1'b0; ts16_rx = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(mf_aligned == 1'b0, "R1 reset lock", int'(mf_aligned), 0);
    chk(tx_f0_ts16 == 8'h0F, "R1 reset tx", int'(tx_f0_ts16), 15);
    chk(sig_stb == 1'b0, "R1 reset strobe", int'(sig_stb), 0);

    // R2: first octet after reset is no candidate
    mf(1);
    send(gen_oct(0)); gen_f = 1;
    chk(mf_aligned == 1'b0, "R2 no lock from first octet", int'(mf_aligned), 0);
    mf(1);
    chk(mf_aligned == 1'b1, "R3 lock after confirm", int'(mf_aligned), 1);
    chk(frame_num == 4'd0, "R4 frame 0 at lock", int'(frame_num), 0);
    mf(4);

    // R5: one bad frame 0 tolerated
    send(8'h8B); gen_f = 1;
    for (int i = 1; i < 16; i++) send(gen_oct(i));
    gen_f = 0;
    chk(mf_aligned == 1'b1, "R5 single bad tolerated", int'(mf_aligned), 1);
    mf(1);
    // R5: two consecutive bad frame 0 octets lose lock
    for (int j = 0; j < 2; j++) begin
      send(8'hC3);
      for (int i = 1; i < 16; i++) send(gen_oct(i));
    end
    send(8'h9B);
    chk(mf_aligned == 1'b0, "R5 lock lost after two bad", int'(mf_aligned), 0);
    for (int i = 2; i < 16; i++) send(gen_oct(i));
    gen_f = 0;
    mf(3);
    chk(mf_aligned == 1'b1, "R3 relock", int'(mf_aligned), 1);

    // R6: one all-zero multiframe loses lock
    for (int i = 0; i < 15; i++) send(8'h00);
    chk(mf_aligned == 1'b1, "R6 still locked before frame 15", int'(mf_aligned), 1);
    send(8'h00);
    chk(mf_aligned == 1'b0, "R6 lock lost on zero multiframe", int'(mf_aligned), 0);
    chk(tx_f0_ts16 == 8'h0F, "R7 Y set after loss", int'(tx_f0_ts16), 15);
    gen_f = 0;
    mf(3);

    // noisy stream with stray zero nibbles, compared frame by frame
    for (int i = 0; i < 300; i++) begin
      logic [7:0] o;
      o = $urandom;
      if (($urandom % 4) == 0) o[7:4] = 4'h0;
      if (($urandom % 16) == 0) o = 8'h00;
      send(o);
    end
    gen_f = 0;
    mf(5);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule